// File: doc/BRIEF.md
# Single-Phase PCI Target with Forced Disconnect

This block is the PCI-side front end of a bridge that forwards cycles to a slow secondary bus. It watches each address phase and claims memory and I/O read and write cycles whose address falls inside one of two windows. A claimed cycle turns into one request on a ready/valid style slow-bus port, and the target stays not-ready until that request completes. When the slow side answers, the block signals target-ready and stop together, so exactly one data word moves. Any burst the initiator intended is cut off after that word. No latency timer is needed: a forwarded cycle always takes longer than the bus allows between data phases, so the block always disconnects.

Parity runs alongside the cycle. For read data the block drives the parity bit one clock after the data it covers. For the address phase and for write data it checks the incoming parity bit one clock later. A mismatch gives a one-clock error pulse, and only when parity checking is enabled.

Top module: `onephase_target`

## Requirements
- R1: A cycle is claimed (`tgt_claim_n` low on the clock after the first clock with `bus_frame_n` low) only when the command on `bus_cmd_be` is one of 4'b0010 (I/O read), 4'b0011 (I/O write), 4'b0110 (memory read), 4'b0111 (memory write), 4'b1100 or 4'b1110 (memory read variants), or 4'b1111 (memory write variant). The address must also lie in its window: memory addresses whose upper 16 bits equal 16'h8000, and I/O addresses whose upper 24 bits equal 24'h000010. Any other cycle leaves every output idle and raises no slow-bus request.
- R2: Each claimed cycle raises exactly one slow-bus request. The request carries the address and the byte-enable lanes unchanged, a write flag (command bit 0), an I/O flag, and for writes the data word. It is held stable until `sb_ack` completes it.
- R3: `tgt_ready_n` stays high while the slow-bus request is outstanding. It goes low on the clock after the handshake, always together with `tgt_stop_n` and while `tgt_claim_n` is low.
- R4: Exactly one data word is transferred per claimed cycle. After the transfer clock (`tgt_ready_n` and `ini_ready_n` both low), `tgt_ready_n` returns high and stays high, even when the initiator keeps `bus_frame_n` low and even for the burst-style commands.
- R5: For reads, `ad_out` carries the data returned with `sb_ack`, and `ad_oe` is high while `tgt_ready_n` is low.
- R6: After the transfer, if `bus_frame_n` is still low, `tgt_stop_n` and `tgt_claim_n` stay low until a clock samples `bus_frame_n` high, and are released on that clock. If `bus_frame_n` is already high at the transfer clock, they are released on the transfer clock.
- R7: For reads, one clock after the data word is driven, `par_oe` is high and `par_out` equals the XOR of that word and `bus_cmd_be`, so the total count of ones across the three is even.
- R8: For a claimed cycle, the address phase and each accepted write word are checked against `bus_par` on the following clock. Each mismatch gives exactly one clock of `perr` high.
- R9: With `perr_en` low at the checking clock, a parity mismatch leaves `perr` low.
- R10: A synchronous active-low reset sets `tgt_claim_n`, `tgt_ready_n` and `tgt_stop_n` high and clears `ad_oe`, `par_oe`, `perr` and `sb_valid`. A reset in the middle of a cycle abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_frame_n | input | 1 | Cycle framing from the initiator, active low |
| ini_ready_n | input | 1 | Initiator ready, active low |
| bus_ad | input | AD_W | Multiplexed address/data lines as seen on the bus |
| bus_cmd_be | input | BE_W | Command in the address phase, byte enables in data phases |
| bus_par | input | 1 | Parity bit as seen on the bus |
| perr_en | input | 1 | Enables parity error reporting |
| tgt_claim_n | output | 1 | Device-select response, active low |
| tgt_ready_n | output | 1 | Target ready, active low |
| tgt_stop_n | output | 1 | Target stop request, active low |
| ad_out | output | AD_W | Read data to drive onto the bus |
| ad_oe | output | 1 | Output enable for `ad_out` |
| par_out | output | 1 | Generated parity for read data |
| par_oe | output | 1 | Output enable for `par_out` |
| perr | output | 1 | One-clock parity error pulse |
| sb_valid | output | 1 | Slow-bus request valid |
| sb_write | output | 1 | Request is a write |
| sb_io | output | 1 | Request targets I/O space |
| sb_addr | output | AD_W | Request address |
| sb_wdata | output | AD_W | Write data |
| sb_be | output | BE_W | Byte-enable lanes, as on the bus |
| sb_ack | input | 1 | Slow-bus completion; request finishes on a clock with `sb_valid` and `sb_ack` high |
| sb_rdata | input | AD_W | Read data, valid with `sb_ack` |

## Verification
The main path is exercised with all seven accepted commands, reads and writes, in both address spaces. Single-word initiators, which drop the frame with the first data phase, are mixed with burst initiators, which hold it, to separate the immediate release from the held stop. Slow-bus delays from zero to seven clocks show that target-ready tracks the handshake and not a fixed count. Out-of-window addresses and an unsupported command show that decode needs both space and command. Corrupted address and write parity, with reporting on and off, separate the check and its enable from read parity generation.

// File: rtl/opt_pkg.sv
// Shared definitions for the single-phase target.
// Assumes a 4-bit command field carried on the byte-enable lines.
package opt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a new address phase
        ST_CLAIM,  // claimed, waiting to issue the slow-bus request
        ST_WAIT,   // slow-bus request outstanding, ready withheld
        ST_DATA,   // ready and stop driven together
        ST_HOLD    // word moved, stop held until frame ends
    } opt_state_e;

    localparam logic [3:0] CMD_IO_RD   = 4'b0010;
    localparam logic [3:0] CMD_IO_WR   = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
    localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
    localparam logic [3:0] CMD_MEM_RDL = 4'b1110;
    localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

endpackage

// File: rtl/opt_decode.sv
// Address-phase decoder: decides whether a command/address pair is claimed.
// Assumes window sizes are powers of two and bases are aligned to them.
module opt_decode
    import opt_pkg::*;
#(
    parameter int              AD_W         = 32,
    parameter int              BE_W         = 4,
    parameter logic [AD_W-1:0] MEM_BASE     = 32'h8000_0000,
    parameter int              MEM_WIN_LOG2 = 16,
    parameter logic [AD_W-1:0] IO_BASE      = 32'h0000_1000,
    parameter int              IO_WIN_LOG2  = 8
) (
    input  logic [AD_W-1:0] addr,
    input  logic [BE_W-1:0] cmd,
    output logic            hit,
    output logic            is_write,
    output logic            is_io
);
    localparam logic [AD_W-1:0] MEM_MASK = ~((AD_W'(1) << MEM_WIN_LOG2) - AD_W'(1));
    localparam logic [AD_W-1:0] IO_MASK  = ~((AD_W'(1) << IO_WIN_LOG2) - AD_W'(1));

    logic mem_cmd, io_cmd, mem_in, io_in;

    // Classify the command into memory, I/O or unsupported.
    always_comb begin
        mem_cmd = 1'b0;
        io_cmd  = 1'b0;
        case (cmd)
            CMD_IO_RD, CMD_IO_WR:                               io_cmd  = 1'b1;
            CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RDM,
            CMD_MEM_RDL, CMD_MEM_WRI:                           mem_cmd = 1'b1;
            default: ;
        endcase
    end

    // Compare the address against each window.
    always_comb begin
        mem_in = ((addr ^ MEM_BASE) & MEM_MASK) == '0;
        io_in  = ((addr ^ IO_BASE) & IO_MASK) == '0;
    end

    assign hit      = (mem_cmd && mem_in) || (io_cmd && io_in);
    assign is_write = cmd[0];
    assign is_io    = io_cmd;

endmodule

// File: rtl/opt_parity.sv
// Parity generator and checker. Generates even parity for driven read data
// one clock late, and checks sampled address/write phases one clock late.
// Assumes the caller arms a check on exactly the clock the phase is sampled.
module opt_parity #(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] bus_ad,
    input  logic [BE_W-1:0] bus_cmd_be,
    input  logic            bus_par,
    input  logic            chk_arm,
    input  logic            perr_en,
    input  logic [AD_W-1:0] gen_data,
    input  logic            gen_oe,
    output logic            par_out,
    output logic            par_oe,
    output logic            perr
);
    logic exp_q, arm_q;

    // Generate parity for the word driven this clock, valid next clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
        end else begin
            par_out <= ^{gen_data, bus_cmd_be};
            par_oe  <= gen_oe;
        end
    end

    // Remember the expected parity of a sampled phase for next-clock check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= 1'b0;
            arm_q <= 1'b0;
        end else begin
            exp_q <= ^{bus_ad, bus_cmd_be};
            arm_q <= chk_arm;
        end
    end

    // Compare the incoming parity bit and raise a one-clock error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) perr <= 1'b0;
        else        perr <= arm_q && perr_en && (bus_par != exp_q);
    end

endmodule

// File: rtl/opt_seq.sv
// Cycle sequencer: claims decoded cycles, issues one slow-bus request,
// then drives ready and stop together so that only one word moves.
// Assumes the slow bus raises sb_ack only while sb_valid is high.
module opt_seq
    import opt_pkg::*;
#(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_frame_n,
    input  logic            ini_ready_n,
    input  logic [AD_W-1:0] bus_ad,
    input  logic [BE_W-1:0] bus_cmd_be,
    input  logic            dec_hit,
    input  logic            dec_write,
    input  logic            dec_io,
    input  logic            sb_ack,
    input  logic [AD_W-1:0] sb_rdata,
    output logic            tgt_claim_n,
    output logic            tgt_ready_n,
    output logic            tgt_stop_n,
    output logic [AD_W-1:0] ad_out,
    output logic            ad_oe,
    output logic            chk_arm,
    output logic            sb_valid,
    output logic            sb_write,
    output logic            sb_io,
    output logic [AD_W-1:0] sb_addr,
    output logic [AD_W-1:0] sb_wdata,
    output logic [BE_W-1:0] sb_be
);
    opt_state_e state;
    logic       frame_q;
    logic       start;

    assign start   = (state == ST_IDLE) && !bus_frame_n && frame_q;
    assign chk_arm = (start && dec_hit) ||
                     ((state == ST_CLAIM) && sb_write && !ini_ready_n);

    // Track the previous frame level to find the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= 1'b1;
        else        frame_q <= bus_frame_n;
    end

    // Main state machine and registered bus/slow-bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            tgt_claim_n <= 1'b1;
            tgt_ready_n <= 1'b1;
            tgt_stop_n  <= 1'b1;
            ad_out      <= '0;
            ad_oe       <= 1'b0;
            sb_valid    <= 1'b0;
            sb_write    <= 1'b0;
            sb_io       <= 1'b0;
            sb_addr     <= '0;
            sb_wdata    <= '0;
            sb_be       <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start && dec_hit) begin
                        tgt_claim_n <= 1'b0;
                        sb_addr     <= bus_ad;
                        sb_write    <= dec_write;
                        sb_io       <= dec_io;
                        state       <= ST_CLAIM;
                    end
                end
                ST_CLAIM: begin
                    if (!sb_write || !ini_ready_n) begin
                        sb_be    <= bus_cmd_be;
                        sb_wdata <= bus_ad;
                        sb_valid <= 1'b1;
                        state    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (sb_ack) begin
                        sb_valid    <= 1'b0;
                        tgt_ready_n <= 1'b0;
                        tgt_stop_n  <= 1'b0;
                        if (!sb_write) begin
                            ad_out <= sb_rdata;
                            ad_oe  <= 1'b1;
                        end
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (!ini_ready_n) begin
                        tgt_ready_n <= 1'b1;
                        ad_oe       <= 1'b0;
                        if (bus_frame_n) begin
                            tgt_stop_n  <= 1'b1;
                            tgt_claim_n <= 1'b1;
                            state       <= ST_IDLE;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (bus_frame_n) begin
                        tgt_stop_n  <= 1'b1;
                        tgt_claim_n <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/onephase_target.sv
// Top level of the single-phase target: decoder, sequencer and parity unit.
// Assumes BE_W is 4 so the command fits the byte-enable lines.
module onephase_target #(
    parameter int              AD_W         = 32,
    parameter int              BE_W         = 4,
    parameter logic [AD_W-1:0] MEM_BASE     = 32'h8000_0000,
    parameter int              MEM_WIN_LOG2 = 16,
    parameter logic [AD_W-1:0] IO_BASE      = 32'h0000_1000,
    parameter int              IO_WIN_LOG2  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_frame_n,
    input  logic            ini_ready_n,
    input  logic [AD_W-1:0] bus_ad,
    input  logic [BE_W-1:0] bus_cmd_be,
    input  logic            bus_par,
    input  logic            perr_en,
    output logic            tgt_claim_n,
    output logic            tgt_ready_n,
    output logic            tgt_stop_n,
    output logic [AD_W-1:0] ad_out,
    output logic            ad_oe,
    output logic            par_out,
    output logic            par_oe,
    output logic            perr,
    output logic            sb_valid,
    output logic            sb_write,
    output logic            sb_io,
    output logic [AD_W-1:0] sb_addr,
    output logic [AD_W-1:0] sb_wdata,
    output logic [BE_W-1:0] sb_be,
    input  logic            sb_ack,
    input  logic [AD_W-1:0] sb_rdata
);
    logic dec_hit, dec_write, dec_io, chk_arm;

    // Address-phase decode.
    opt_decode #(
        .AD_W(AD_W), .BE_W(BE_W),
        .MEM_BASE(MEM_BASE), .MEM_WIN_LOG2(MEM_WIN_LOG2),
        .IO_BASE(IO_BASE), .IO_WIN_LOG2(IO_WIN_LOG2)
    ) u_dec (
        .addr(bus_ad), .cmd(bus_cmd_be),
        .hit(dec_hit), .is_write(dec_write), .is_io(dec_io)
    );

    // Cycle sequencing and slow-bus request.
    opt_seq #(.AD_W(AD_W), .BE_W(BE_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .bus_frame_n(bus_frame_n), .ini_ready_n(ini_ready_n),
        .bus_ad(bus_ad), .bus_cmd_be(bus_cmd_be),
        .dec_hit(dec_hit), .dec_write(dec_write), .dec_io(dec_io),
        .sb_ack(sb_ack), .sb_rdata(sb_rdata),
        .tgt_claim_n(tgt_claim_n), .tgt_ready_n(tgt_ready_n), .tgt_stop_n(tgt_stop_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .chk_arm(chk_arm),
        .sb_valid(sb_valid), .sb_write(sb_write), .sb_io(sb_io),
        .sb_addr(sb_addr), .sb_wdata(sb_wdata), .sb_be(sb_be)
    );

    // Parity generation and checking.
    opt_parity #(.AD_W(AD_W), .BE_W(BE_W)) u_par (
        .clk(clk), .rst_n(rst_n),
        .bus_ad(bus_ad), .bus_cmd_be(bus_cmd_be), .bus_par(bus_par),
        .chk_arm(chk_arm), .perr_en(perr_en),
        .gen_data(ad_out), .gen_oe(ad_oe),
        .par_out(par_out), .par_oe(par_oe), .perr(perr)
    );

endmodule

// File: rtl/opt_checker.sv
// Protocol checker for onephase_target, attached by bind below.
// Assumes it sees the top-level ports only.
module opt_checker #(
    parameter int AD_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_frame_n,
    input logic            ini_ready_n,
    input logic            perr_en,
    input logic            tgt_claim_n,
    input logic            tgt_ready_n,
    input logic            tgt_stop_n,
    input logic            ad_oe,
    input logic            par_oe,
    input logic            perr,
    input logic            sb_valid,
    input logic            sb_ack,
    input logic [AD_W-1:0] sb_addr
);
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_valid && !sb_ack) |=> (sb_valid && $stable(sb_addr)));

    a_r3_ready_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_ready_n |-> !tgt_stop_n);

    a_r3_ready_while_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_ready_n |-> !tgt_claim_n);

    a_r4_one_word: assert property (@(posedge clk) disable iff (!rst_n)
        (!tgt_ready_n && !ini_ready_n) |=> tgt_ready_n);

    a_r6_stop_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!tgt_stop_n && tgt_ready_n && !bus_frame_n) |=> !tgt_stop_n);

    a_r7_par_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> $past(ad_oe));

    a_r9_perr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        perr |-> $past(perr_en));

endmodule

bind onephase_target opt_checker #(.AD_W(AD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_frame_n(bus_frame_n), .ini_ready_n(ini_ready_n),
    .perr_en(perr_en), .tgt_claim_n(tgt_claim_n), .tgt_ready_n(tgt_ready_n),
    .tgt_stop_n(tgt_stop_n), .ad_oe(ad_oe), .par_oe(par_oe), .perr(perr),
    .sb_valid(sb_valid), .sb_ack(sb_ack), .sb_addr(sb_addr)
);

// File: tb/sim_onephase_target.sv
`timescale 1ns/1ps
module sim_onephase_target;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_frame_n = 1'b1, ini_ready_n = 1'b1, bus_par = 1'b0, perr_en = 1'b1;
    logic [31:0] bus_ad = '0;
    logic [3:0]  bus_cmd_be = '0;
    logic        sb_ack = 1'b0;
    logic [31:0] sb_rdata = '0;
    logic        tgt_claim_n, tgt_ready_n, tgt_stop_n, ad_oe, par_out, par_oe, perr;
    logic        sb_valid, sb_write, sb_io;
    logic [31:0] ad_out, sb_addr, sb_wdata;
    logic [3:0]  sb_be;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    onephase_target u0 (
        .clk(clk), .rst_n(rst_n), .bus_frame_n(bus_frame_n), .ini_ready_n(ini_ready_n),
        .bus_ad(bus_ad), .bus_cmd_be(bus_cmd_be), .bus_par(bus_par), .perr_en(perr_en),
        .tgt_claim_n(tgt_claim_n), .tgt_ready_n(tgt_ready_n), .tgt_stop_n(tgt_stop_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe), .perr(perr),
        .sb_valid(sb_valid), .sb_write(sb_write), .sb_io(sb_io), .sb_addr(sb_addr),
        .sb_wdata(sb_wdata), .sb_be(sb_be), .sb_ack(sb_ack), .sb_rdata(sb_rdata)
    );

    typedef struct packed {
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic        burst;
        logic [3:0]  delay;
        logic        bad_a;
        logic        bad_d;
        logic        hit;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'b0111, 32'h8000_0010, 32'hA5A5_1234, 4'b0000, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1},
        '{4'b0110, 32'h8000_FFFC, 32'h1357_9BDF, 4'b0011, 1'b0, 4'd3, 1'b0, 1'b0, 1'b1},
        '{4'b0011, 32'h0000_10F0, 32'h0000_00FF, 4'b1110, 1'b1, 4'd5, 1'b0, 1'b0, 1'b1},
        '{4'b0010, 32'h0000_1004, 32'hCAFE_F00D, 4'b0000, 1'b1, 4'd1, 1'b0, 1'b0, 1'b1},
        '{4'b1100, 32'h8000_0100, 32'h0F0F_0F0F, 4'b0000, 1'b1, 4'd2, 1'b0, 1'b0, 1'b1},
        '{4'b1111, 32'h8000_0200, 32'hFFFF_FFFF, 4'b0000, 1'b1, 4'd0, 1'b0, 1'b0, 1'b1},
        '{4'b1110, 32'h8000_0300, 32'h8000_0001, 4'b0101, 1'b0, 4'd7, 1'b0, 1'b0, 1'b1},
        '{4'b0110, 32'h8001_0000, 32'h1111_1111, 4'b0000, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0},
        '{4'b0011, 32'h0000_1100, 32'h2222_2222, 4'b0000, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0},
        '{4'b1010, 32'h8000_0000, 32'h3333_3333, 4'b0000, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0},
        '{4'b0111, 32'h8000_0040, 32'h0000_0001, 4'b1100, 1'b0, 4'd1, 1'b1, 1'b1, 1'b1},
        '{4'b0110, 32'h8000_0044, 32'h7777_0000, 4'b0000, 1'b1, 4'd0, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Run one cycle from the table and check every observable step.
    task automatic run_vec(input vec_t v);
        bit wr = v.cmd[0];
        bit io = (v.cmd[3:1] == 3'b001);
        int perr_cnt = 0;
        int ack_it = -10;
        int acks = 0;
        int wait_cnt = 0;
        bit seen_req = 1'b0;
        bit xfer = 1'b0;
        int exp_perr;
        exp_perr = perr_en ? (int'(v.bad_a) + int'(wr & v.bad_d)) : 0;

        @(negedge clk);
        bus_frame_n = 1'b0; bus_ad = v.addr; bus_cmd_be = v.cmd; ini_ready_n = 1'b1;
        @(negedge clk);
        chk(tgt_claim_n == !v.hit, "R1 claim decision", 32'(tgt_claim_n), 32'(!v.hit));
        chk(tgt_ready_n, "R3 ready high at claim", 32'(tgt_ready_n), 32'd1);
        bus_par = ^{v.addr, v.cmd} ^ v.bad_a;
        bus_ad = wr ? v.data : 32'h0;
        bus_cmd_be = v.be;
        ini_ready_n = 1'b0;
        bus_frame_n = v.burst ? 1'b0 : 1'b1;

        if (!v.hit) begin
            bit bad = 1'b0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (!tgt_claim_n || sb_valid || !tgt_ready_n || !tgt_stop_n || perr) bad = 1'b1;
            end
            chk(!bad, "R1 unclaimed cycle ignored", 32'(bad), 32'd0);
            bus_frame_n = 1'b1; ini_ready_n = 1'b1;
            @(negedge clk);
            return;
        end

        for (int it = 0; it < 40; it++) begin
            @(negedge clk);
            if (it == 0) bus_par = wr ? (^{v.data, v.be} ^ v.bad_d) : 1'b0;
            if (perr) perr_cnt++;
            if (!tgt_ready_n) begin
                chk(ack_it == it - 1, "R3 ready on clock after handshake", 32'(it), 32'(ack_it + 1));
                chk(!tgt_stop_n && !tgt_claim_n, "R3 ready with stop and claim",
                    {30'd0, tgt_stop_n, tgt_claim_n}, 32'd0);
                if (!wr) chk(ad_oe && ad_out == v.data, "R5 read data on bus", ad_out, v.data);
                sb_ack = 1'b0;
                xfer = 1'b1;
                break;
            end
            if (sb_valid && !sb_ack) begin
                if (!seen_req) begin
                    seen_req = 1'b1;
                    chk(sb_addr == v.addr && sb_write == wr && sb_io == io && sb_be == v.be,
                        "R2 request fields", sb_addr, v.addr);
                    if (wr) chk(sb_wdata == v.data, "R2 write data", sb_wdata, v.data);
                end
                if (wait_cnt == int'(v.delay)) begin
                    sb_ack = 1'b1; sb_rdata = v.data; ack_it = it; acks++;
                end else wait_cnt++;
            end else if (sb_ack) begin
                sb_ack = 1'b0;
            end
            if (ack_it < 0) chk(tgt_ready_n, "R3 ready withheld while pending", 32'(tgt_ready_n), 32'd1);
        end
        chk(xfer, "R3 ready eventually asserted", 32'(xfer), 32'd1);
        chk(acks == 1 && !sb_valid, "R2 exactly one request", 32'(acks), 32'd1);

        @(negedge clk);
        if (perr) perr_cnt++;
        chk(tgt_ready_n, "R4 ready drops after one word", 32'(tgt_ready_n), 32'd1);
        if (!wr) chk(par_oe && par_out == ^{v.data, v.be}, "R7 read parity", 32'(par_out), 32'(^{v.data, v.be}));
        if (v.burst) begin
            chk(!tgt_stop_n && !tgt_claim_n, "R6 stop held while frame low",
                {30'd0, tgt_stop_n, tgt_claim_n}, 32'd0);
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                if (perr) perr_cnt++;
                chk(tgt_ready_n && !tgt_stop_n, "R4 no second word in burst",
                    {30'd0, tgt_ready_n, tgt_stop_n}, 32'd2);
            end
            bus_frame_n = 1'b1; ini_ready_n = 1'b1;
            @(negedge clk);
            if (perr) perr_cnt++;
        end else begin
            ini_ready_n = 1'b1;
        end
        chk(tgt_stop_n && tgt_claim_n, "R6 release after frame high",
            {30'd0, tgt_stop_n, tgt_claim_n}, 32'd3);
        @(negedge clk);
        if (perr) perr_cnt++;
        chk(perr_cnt == exp_perr, perr_en ? "R8 parity error pulses" : "R9 errors suppressed",
            32'(perr_cnt), 32'(exp_perr));
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tgt_claim_n && tgt_ready_n && tgt_stop_n && !ad_oe && !par_oe && !perr && !sb_valid,
            "R10 reset state", {25'd0, tgt_claim_n, tgt_ready_n, tgt_stop_n, ad_oe, par_oe, perr, sb_valid},
            32'h70);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: corrupted parity with reporting disabled.
        perr_en = 1'b0;
        run_vec('{4'b0111, 32'h8000_0080, 32'h0000_00F0, 4'b0000, 1'b0, 4'd1, 1'b1, 1'b1, 1'b1});
        perr_en = 1'b1;

        // R10: reset in the middle of a claimed cycle.
        @(negedge clk);
        bus_frame_n = 1'b0; bus_ad = 32'h8000_0500; bus_cmd_be = 4'b0110;
        @(negedge clk);
        chk(!tgt_claim_n, "R1 claim before mid-cycle reset", 32'(tgt_claim_n), 32'd0);
        bus_cmd_be = 4'b0000; ini_ready_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(tgt_claim_n && tgt_ready_n && tgt_stop_n && !sb_valid && !ad_oe,
            "R10 mid-cycle reset abandons cycle",
            {27'd0, tgt_claim_n, tgt_ready_n, tgt_stop_n, sb_valid, ad_oe}, 32'h1C);
        bus_frame_n = 1'b1; ini_ready_n = 1'b1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Recovery after reset: a normal write completes.
        run_vec(VECS[0]);

        summary();
        $finish;
    end

endmodule